// File: doc/BRIEF.md
# Forty-Bit Free-Running Time Base

This block keeps a wide, steadily increasing count for use as a stable system time reference. After reset it is idle at zero. Software starts it by setting an enable bit in the upper register. From then on the count goes up by one for every cycle in which the external tick-enable input is high. The intended tick rate is 983.04 kHz. There is no reload value, no compare logic and no interrupt. When the count passes its largest value it wraps back to zero.

The 40-bit value is read through two 32-bit registers. The lower register returns the bottom 32 count bits. The upper register returns the top 8 count bits in its low byte and the enable state in bit 8. Reading the lower register copies the top count bits into a shadow byte, and the upper register returns that shadow. A read of the lower word followed by a read of the upper word therefore gives one consistent 40-bit sample, even if ticks arrive between the two reads. Writing the enable bit as 0 stops the count and clears it.

The count width and the split point are parameters. With the defaults the count is 40 bits and the lower register holds 32 of them. A narrower build behaves the same way and only wraps sooner.

Top module: `free_timebase`

## Requirements
- R1: After reset the count is zero, counting is disabled, and `bus_rdata_o` is zero.
- R2: While enabled, the count increases by exactly one at each clock edge where `tick_i` is 1. It holds its value when `tick_i` is 0 or when counting is disabled.
- R3: When the count equals its all-ones value and one more tick arrives, the count becomes zero.
- R4: A write to the upper register (address 0x64) with bit 8 set enables counting. If counting is already enabled, such a write leaves the count unchanged. Bits 7:0 of that write are ignored, and writes to any other address, including the lower register (0x60), have no effect.
- R5: A write to the upper register with bit 8 clear disables counting and sets the count to zero. This clear wins over a tick at the same edge.
- R6: A read of the lower register (0x60) places the low count bits, zero-extended to 32 bits, on `bus_rdata_o` one cycle later. The value is the count as it stood before that edge's tick.
- R7: A lower-register read copies the upper count bits into a shadow. A read of the upper register (0x64) returns the shadow in bits 7:0 and the enable state in bit 8, with bits 31:9 reading as zero.
- R8: A read of any other address returns zero. `bus_rdata_o` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-advance enable, one clock cycle wide per tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |

## Verification
- **Ticks and writes:** a tick or a write sampled at an edge changes the count or the enable state at that same edge.
- **Reads:** read data is registered, so it appears in the cycle after the read strobe. It shows the state from before that edge's update.
- **Where results are sampled:** the bench drives every strobe on the falling edge and samples `bus_rdata_o` on the following falling edge, half a cycle after the edge that registered it. Count values are seen only through reads, so the count after each pattern is observed one cycle after the read that exposes it.
- **Wrap and coherence:** a second, narrow build (10-bit count, 6 low bits) lets the bench reach the wrap point and the carry into the upper register within a short run.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  // Next count value for a counter of width w, wrapping at 2**w.
  function automatic logic [63:0] cnt_step(input logic [63:0] v, input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'(1) << w) - 64'(1));
    return (v + 64'(1)) & mask;
  endfunction

  // Upper register image: shadow byte in the low bits, enable at en_bit.
  function automatic logic [31:0] hi_image(input logic [31:0] shadow, input logic run,
                                           input int unsigned en_bit);
    logic [31:0] r;
    r = shadow;
    r[en_bit] = run;
    return r;
  endfunction

endpackage

// File: rtl/tbase_counter.sv
module tbase_counter
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             set_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             inc_evt;

  assign inc_evt = run_q && tick_i && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (clr_i) begin
      run_q <= 1'b0;
    end else if (set_i) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_evt) begin
      cnt_q <= CNT_W'(cnt_step(64'(cnt_q), CNT_W));
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R2: hold when there is no tick
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

  // R2: one step per enabled tick
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !clr_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: all-ones plus a tick gives zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !clr_i && (&cnt_q)) |=> (cnt_q == '0));

  // R5: a clear stops and zeroes the count
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !run_q));

  // R4: a set leaves the counter running
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> run_q);

endmodule

// File: rtl/tbase_regif.sv
module tbase_regif
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned LO_W    = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned EN_BIT  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              run_i,
  output logic              set_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned HI_W = CNT_W - LO_W;

  logic [HI_W-1:0]   shadow_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_lo, hit_hi;
  logic              rd_lo_evt, rd_hi_evt, rd_miss_evt;

  assign hit_lo      = (addr_i == LO_ADDR);
  assign hit_hi      = (addr_i == HI_ADDR);
  assign rd_lo_evt   = rd_i && hit_lo;
  assign rd_hi_evt   = rd_i && hit_hi;
  assign rd_miss_evt = rd_i && !hit_lo && !hit_hi;
  assign set_o       = wr_i && hit_hi && wdata_i[EN_BIT];
  assign clr_o       = wr_i && hit_hi && !wdata_i[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (rd_lo_evt) begin
      shadow_q <= cnt_i[CNT_W-1:LO_W];
    end else if (clr_o) begin
      shadow_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_lo_evt) begin
      rdata_q <= DATA_W'(cnt_i[LO_W-1:0]);
    end else if (rd_hi_evt) begin
      rdata_q <= DATA_W'(hi_image(32'(shadow_q), run_i, EN_BIT));
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // R7: lower read captures the upper count bits
  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_evt |=> (shadow_q == $past(cnt_i[CNT_W-1:LO_W])));

  // R7: padding above the enable bit reads as zero
  assert_hi_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_evt |=> (rdata_q[DATA_W-1:EN_BIT+1] == '0));

  // R8: unmapped reads and idle cycles return zero
  assert_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss_evt || !rd_i) |=> (rdata_q == '0));

  // R6: lower read returns the pre-edge count
  assert_lo_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_evt |=> (rdata_q == DATA_W'($past(cnt_i[LO_W-1:0]))));

endmodule

// File: rtl/free_timebase.sv
module free_timebase #(
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned LO_W   = 32,
  parameter int unsigned EN_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o
);

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             set_evt;
  logic             clr_evt;

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .set_i  (set_evt),
    .clr_i  (clr_evt),
    .cnt_o  (cnt),
    .run_o  (run)
  );

  tbase_regif #(
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .DATA_W (32),
    .ADDR_W (8),
    .EN_BIT (EN_BIT)
  ) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt),
    .run_i   (run),
    .set_o   (set_evt),
    .clr_o   (clr_evt),
    .rdata_o (bus_rdata_o)
  );

  // R4: a write elsewhere never changes the enable state
  assert_no_stray_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr_i && bus_addr_i == 8'h64)) |=> (run == $past(run)));

endmodule

// File: tb/test_free_timebase.sv
module test_free_timebase;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick = '0;
  logic [1:0]  wr = '0;
  logic [1:0]  rd = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  free_timebase i_free_timebase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick[0]), .bus_wr_i(wr[0]), .bus_rd_i(rd[0]),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a)
  );

  // Narrow build: 10-bit count, 6 low bits, 4 upper bits.
  free_timebase #(.CNT_W(10), .LO_W(6)) i_small (
    .clk(clk), .rst_n(rst_n), .tick_i(tick[1]), .bus_wr_i(wr[1]), .bus_rd_i(rd[1]),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_ticks(input int s, input int n);
    @(negedge clk); tick[s] = 1'b1;
    repeat (n) @(negedge clk);
    tick[s] = 1'b0;
  endtask

  task automatic do_write(input int s, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr[s] = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr[s] = 1'b0;
  endtask

  task automatic do_read(input int s, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd[s] = 1'b1; addr = a;
    @(negedge clk); rd[s] = 1'b0;
    d = (s == 0) ? rdata_a : rdata_b;
  endtask

  // Vector: op(2) addr(8) data(32) expected(32). op 0=ticks 1=write 2=read.
  localparam int NV = 17;
  localparam logic [73:0] VEC [NV] = '{
    {2'd2, 8'h60, 32'h0,     32'h0},       // R1 lower reads zero
    {2'd2, 8'h64, 32'h0,     32'h0},       // R1 upper reads zero, disabled
    {2'd0, 8'h00, 32'd5,     32'h0},       // R2 ticks while disabled
    {2'd2, 8'h60, 32'h0,     32'h0},       // R2 no count while disabled
    {2'd1, 8'h60, 32'h100,   32'h0},       // R4 write to lower ignored
    {2'd2, 8'h64, 32'h0,     32'h0},       // R4 still disabled
    {2'd1, 8'h64, 32'h100,   32'h0},       // R4 enable
    {2'd0, 8'h00, 32'd7,     32'h0},       // R2 seven ticks
    {2'd2, 8'h60, 32'h0,     32'd7},       // R6 lower returns 7
    {2'd2, 8'h64, 32'h0,     32'h100},     // R7 enable bit, shadow zero
    {2'd1, 8'h64, 32'h1FF,   32'h0},       // R4 re-enable, low byte ignored
    {2'd0, 8'h00, 32'd3,     32'h0},       // R2 three more ticks
    {2'd2, 8'h60, 32'h0,     32'd10},      // R4 no clear on re-enable
    {2'd2, 8'h68, 32'h0,     32'h0},       // R8 unmapped read
    {2'd1, 8'h64, 32'h0,     32'h0},       // R5 disable and clear
    {2'd2, 8'h60, 32'h0,     32'h0},       // R5 count cleared
    {2'd2, 8'h64, 32'h0,     32'h0}        // R5 enable bit cleared
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata_a, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: do_ticks(0, int'(VEC[i][63:32]));
        2'd1: do_write(0, VEC[i][71:64], VEC[i][63:32]);
        default: begin
          do_read(0, VEC[i][71:64], d);
          check($sformatf("vector %0d", i), d, VEC[i][31:0]);
        end
      endcase
    end

    // R8: cycle after the read returns to zero
    @(negedge clk);
    check("R8 idle rdata", rdata_a, 32'h0);

    // R7 coherence on the narrow build: reach 63 (low bits all ones)
    do_write(1, 8'h64, 32'h100);
    do_ticks(1, 63);
    do_read(1, 8'h60, d);
    check("R6 small lower at 63", d, 32'd63);
    do_ticks(1, 1);                      // count 64, upper bits now 1
    do_read(1, 8'h64, d);
    check("R7 shadow keeps pre-carry byte", d, 32'h100);
    do_read(1, 8'h60, d);
    check("R7 lower after carry", d, 32'd0);
    do_read(1, 8'h64, d);
    check("R7 shadow refreshed", d, 32'h101);

    // R3 wrap: 64 -> 1023 -> 0
    do_ticks(1, 959);
    do_read(1, 8'h60, d);
    check("R3 lower at max", d, 32'd63);
    do_read(1, 8'h64, d);
    check("R3 upper at max", d, 32'h10F);
    do_ticks(1, 1);
    do_read(1, 8'h60, d);
    check("R3 lower after wrap", d, 32'd0);
    do_read(1, 8'h64, d);
    check("R3 upper after wrap", d, 32'h100);

    // R5 clear beats a tick at the same edge
    do_ticks(1, 4);
    @(negedge clk); wr[1] = 1'b1; addr = 8'h64; wdata = 32'h0; tick[1] = 1'b1;
    @(negedge clk); wr[1] = 1'b0; tick[1] = 1'b0;
    do_read(1, 8'h60, d);
    check("R5 clear wins over tick", d, 32'd0);
    do_read(1, 8'h64, d);
    check("R5 disabled after clear", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule